// File: doc/BRIEF.md
# Integer Execute and Writeback Select

This block is the execute stage of a small single-cycle integer core. The decoder has already classified the instruction and driven a 5-bit operation code. The register file supplies two source values, and the decoder supplies the sign-extended immediate and the current program counter. Within the same cycle the block produces the 32-bit result. It also produces the word index, the write data and the read and write strobes for a word-organised data memory. The value presented to the register-file write port is the result, except for a load, where it is the word that comes back from memory.

The block has no registers and holds no state. One shared adder/subtractor serves the arithmetic operations and also the load and store address. A 64-bit shifter serves all of the shift operations. A comparator builds its signed test from the unsigned compare and the two sign bits.

Top module: `exec_result_unit`

## Requirements
- R1: `op_sel` encoding: 0 none, 1 ADD, 2 SUB, 3 ADDI, 4 AND, 5 OR, 6 XOR, 7 ANDI, 8 ORI, 9 XORI, 10 SLL, 11 SRL, 12 SRA, 13 SLLI, 14 SRLI, 15 SRAI, 16 SLT, 17 SLTU, 18 SLTI, 19 SLTIU, 20 LUI, 21 AUIPC, 22 JAL, 23 JALR, 24 LOAD, 25 STORE. ADD gives src1+src2, SUB gives src1-src2 and ADDI gives src1+imm, all modulo 2^32.
- R2: AND, OR and XOR combine src1 bitwise with src2, and their immediate forms combine src1 with imm.
- R3: SLL and SRL shift src1 left or right by src2[4:0], filling with zeros. SLLI and SRLI use imm[4:0] as the amount. Higher bits of the amount have no effect.
- R4: SRA and SRAI shift src1 right arithmetically by src2[4:0] or imm[4:0], replicating bit 31.
- R5: SLTU gives 1 when src1 < src2 as unsigned numbers and 0 otherwise. SLTIU does the same against imm. Bits 31:1 of the result are zero.
- R6: SLT and SLTI give 1 when src1 is less than src2 (or imm) as two's-complement numbers and 0 otherwise.
- R7: LUI gives {imm[31:12], 12'b0}. AUIPC gives pc plus that value.
- R8: JAL and JALR give pc+4.
- R9: LOAD and STORE give src1+imm as the result. `mem_idx` is bits [6:2] of that sum, `mem_we` is 1 only for STORE and `mem_re` is 1 only for LOAD. `mem_wdata` is always src2.
- R10: `rf_wdata` equals `load_data` during a LOAD and equals `result` for every other code.
- R11: Codes 0 and 26 to 31 give a result of 0, with both memory strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Decoded operation code |
| src1 | input | 32 | First register operand |
| src2 | input | 32 | Second register operand |
| imm | input | 32 | Sign-extended immediate |
| pc | input | 32 | Address of the current instruction |
| load_data | input | 32 | Word read from data memory |
| result | output | 32 | Execute result |
| mem_idx | output | 5 | Data-memory word index |
| mem_wdata | output | 32 | Data-memory write word |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe |
| rf_wdata | output | 32 | Register-file write value |

## Verification
The block holds no state, so a wrong operand-select or mode-select decision appears on `result` or on the memory outputs in the same cycle as the code that triggers it. It does not linger into later operations. The sweep crosses every code, including the unused ones, with operand pairs chosen to sit at the sign boundary, at all ones and at shift amounts whose upper bits are set. Under this sweep, a swapped operand, a wrong fill bit or a misplaced index slice shows up at the ports within one sample.

// File: rtl/eru_pkg.sv
package eru_pkg;
    localparam int XLEN = 32;

    typedef enum logic [4:0] {
        OP_NONE  = 5'd0,  OP_ADD   = 5'd1,  OP_SUB   = 5'd2,  OP_ADDI  = 5'd3,
        OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR   = 5'd6,  OP_ANDI  = 5'd7,
        OP_ORI   = 5'd8,  OP_XORI  = 5'd9,  OP_SLL   = 5'd10, OP_SRL   = 5'd11,
        OP_SRA   = 5'd12, OP_SLLI  = 5'd13, OP_SRLI  = 5'd14, OP_SRAI  = 5'd15,
        OP_SLT   = 5'd16, OP_SLTU  = 5'd17, OP_SLTI  = 5'd18, OP_SLTIU = 5'd19,
        OP_LUI   = 5'd20, OP_AUIPC = 5'd21, OP_JAL   = 5'd22, OP_JALR  = 5'd23,
        OP_LOAD  = 5'd24, OP_STORE = 5'd25
    } op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_e;
endpackage

// File: rtl/eru_addsub.sv
module eru_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         do_sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] rhs_eff;

    always_comb begin
        rhs_eff = do_sub ? ~rhs : rhs;
        sum     = lhs + rhs_eff + {{(W-1){1'b0}}, do_sub};
    end
endmodule

// File: rtl/eru_shifter.sv
module eru_shifter #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]    val,
    input  logic [SW-1:0]   amt,
    input  eru_pkg::shift_e mode,
    output logic [W-1:0]    shifted
);
    import eru_pkg::*;

    logic [2*W-1:0] wide;

    always_comb begin
        wide = {{W{(mode == SH_RARI) & val[W-1]}}, val};
        unique case (mode)
            SH_LEFT: shifted = val << amt;
            SH_RLOG,
            SH_RARI: shifted = W'(wide >> amt);
            default: shifted = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({val, amt, mode}) && mode == SH_RARI && !val[W-1]) begin
            assert_sra_positive_R4: assert (shifted == (val >> amt))
                else $error("arithmetic shift of a positive value differs from logical");
        end
    end
endmodule

// File: rtl/eru_compare.sv
module eru_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         signed_cmp,
    output logic         less
);
    logic ult;

    always_comb begin
        ult = a < b;
        if (signed_cmp && (a[W-1] != b[W-1]))
            less = a[W-1];
        else
            less = ult;
    end

    always_comb begin
        if (!$isunknown({a, b, signed_cmp}) && a == b) begin
            assert_cmp_equal_R6: assert (!less)
                else $error("equal operands reported as less");
        end
    end
endmodule

// File: rtl/exec_result_unit.sv
module exec_result_unit #(
    parameter int MEM_WORDS = 32,
    localparam int IDX_W = $clog2(MEM_WORDS)
) (
    input  logic [4:0]       op_sel,
    input  logic [31:0]      src1,
    input  logic [31:0]      src2,
    input  logic [31:0]      imm,
    input  logic [31:0]      pc,
    input  logic [31:0]      load_data,
    output logic [31:0]      result,
    output logic [IDX_W-1:0] mem_idx,
    output logic [31:0]      mem_wdata,
    output logic             mem_we,
    output logic             mem_re,
    output logic [31:0]      rf_wdata
);
    import eru_pkg::*;

    localparam int W = XLEN;

    op_e          op;
    logic         use_imm;
    logic         do_sub;
    logic         signed_cmp;
    logic         is_cmp;
    shift_e       sh_mode;
    logic [W-1:0] opnd_b;
    logic [W-1:0] sum;
    logic [W-1:0] shifted;
    logic         less;
    logic [W-1:0] upper;

    always_comb begin
        op         = op_e'(op_sel);
        use_imm    = 1'b0;
        do_sub     = 1'b0;
        signed_cmp = 1'b0;
        is_cmp     = 1'b0;
        sh_mode    = SH_LEFT;
        unique case (op_sel)
            OP_ADDI, OP_ANDI, OP_ORI, OP_XORI,
            OP_SLLI, OP_LOAD, OP_STORE, OP_JALR: use_imm = 1'b1;
            OP_SRLI:  begin use_imm = 1'b1; sh_mode = SH_RLOG; end
            OP_SRAI:  begin use_imm = 1'b1; sh_mode = SH_RARI; end
            OP_SRL:   sh_mode = SH_RLOG;
            OP_SRA:   sh_mode = SH_RARI;
            OP_SUB:   do_sub = 1'b1;
            OP_SLT:   begin signed_cmp = 1'b1; is_cmp = 1'b1; end
            OP_SLTI:  begin signed_cmp = 1'b1; is_cmp = 1'b1; use_imm = 1'b1; end
            OP_SLTU:  is_cmp = 1'b1;
            OP_SLTIU: begin is_cmp = 1'b1; use_imm = 1'b1; end
            default:  ;
        endcase
        opnd_b = use_imm ? imm : src2;
        upper  = {imm[31:12], 12'h000};
    end

    eru_addsub #(.W(W)) addsub_i (
        .lhs(src1), .rhs(opnd_b), .do_sub(do_sub), .sum(sum)
    );

    eru_shifter #(.W(W)) shifter_i (
        .val(src1), .amt(opnd_b[4:0]), .mode(sh_mode), .shifted(shifted)
    );

    eru_compare #(.W(W)) compare_i (
        .a(src1), .b(opnd_b), .signed_cmp(signed_cmp), .less(less)
    );

    always_comb begin
        mem_we = 1'b0;
        mem_re = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_ADDI:           result = sum;
            OP_AND, OP_ANDI:                   result = src1 & opnd_b;
            OP_OR,  OP_ORI:                    result = src1 | opnd_b;
            OP_XOR, OP_XORI:                   result = src1 ^ opnd_b;
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLI, OP_SRLI, OP_SRAI:         result = shifted;
            OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU: result = {{(W-1){1'b0}}, less};
            OP_LUI:                            result = upper;
            OP_AUIPC:                          result = pc + upper;
            OP_JAL, OP_JALR:                   result = pc + 32'd4;
            OP_LOAD:  begin result = sum; mem_re = 1'b1; end
            OP_STORE: begin result = sum; mem_we = 1'b1; end
            default:                           result = '0;
        endcase
        mem_idx   = sum[IDX_W+1:2];
        mem_wdata = src2;
        rf_wdata  = mem_re ? load_data : result;
    end

    always_comb begin
        if (!$isunknown({op_sel, src1, src2, imm, pc, load_data})) begin
            assert_strobe_excl_R9: assert (!(mem_we && mem_re))
                else $error("both memory strobes high");
            if (mem_re) begin
                assert_load_writeback_R10: assert (rf_wdata == load_data)
                    else $error("load does not write back memory data");
            end else begin
                assert_alu_writeback_R10: assert (rf_wdata == result)
                    else $error("non-load does not write back result");
            end
            if (is_cmp) begin
                assert_cmp_narrow_R5: assert (result[31:1] == '0)
                    else $error("compare result wider than one bit");
            end
            if (op_sel == 5'd0 || op_sel > 5'd25) begin
                assert_unknown_quiet_R11: assert (result == '0 && !mem_we && !mem_re)
                    else $error("unused code produced activity");
            end
        end
    end
endmodule

// File: tb/exec_result_unit_tb.sv
module exec_result_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [4:0]  op_sel = '0;
    logic [31:0] src1 = '0, src2 = '0, imm = '0, pc = '0, load_data = '0;
    logic [31:0] result, mem_wdata, rf_wdata;
    logic [4:0]  mem_idx;
    logic        mem_we, mem_re;

    int checks = 0;
    int errors = 0;

    exec_result_unit dut_i (
        .op_sel(op_sel), .src1(src1), .src2(src2), .imm(imm), .pc(pc),
        .load_data(load_data), .result(result), .mem_idx(mem_idx),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .rf_wdata(rf_wdata)
    );

    function automatic logic [31:0] pick(int k);
        case (k % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h0000_001F;
            6: return 32'h1234_5678;
            default: return 32'hFFFF_0021;
        endcase
    endfunction

    function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b,
                                          logic [31:0] im, logic [31:0] p);
        logic [31:0] up;
        up = {im[31:12], 12'h000};
        case (op)
            1:  return a + b;
            2:  return a - b;
            3:  return a + im;
            4:  return a & b;
            5:  return a | b;
            6:  return a ^ b;
            7:  return a & im;
            8:  return a | im;
            9:  return a ^ im;
            10: return a << b[4:0];
            11: return a >> b[4:0];
            12: return 32'($signed(a) >>> b[4:0]);
            13: return a << im[4:0];
            14: return a >> im[4:0];
            15: return 32'($signed(a) >>> im[4:0]);
            16: return {31'b0, $signed(a) < $signed(b)};
            17: return {31'b0, a < b};
            18: return {31'b0, $signed(a) < $signed(im)};
            19: return {31'b0, a < im};
            20: return up;
            21: return p + up;
            22, 23: return p + 32'd4;
            24, 25: return a + im;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int op);
        if (op >= 1 && op <= 3) return "R1";
        if (op >= 4 && op <= 9) return "R2";
        if (op == 12 || op == 15) return "R4";
        if (op >= 10 && op <= 15) return "R3";
        if (op == 17 || op == 19) return "R5";
        if (op == 16 || op == 18) return "R6";
        if (op == 20 || op == 21) return "R7";
        if (op == 22 || op == 23) return "R8";
        if (op == 24 || op == 25) return "R9";
        return "R11";
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s op=%0d actual=%h expected=%h", req, what, op_sel, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // All-zero inputs: idle code gives nothing (R11)
        check("R11", "idle result", result, 32'h0);
        check("R11", "idle strobes", {30'b0, mem_we, mem_re}, 32'h0);
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [31:0] a, b, im, p, ld, exp_r, addr;
                    a  = pick(i);
                    b  = pick(j);
                    im = pick(i + j + 3) ^ {26'h0, 6'(j * 7)} ^ 32'h0000_0040;
                    p  = 32'h0000_1000 + 32'(4 * (i * 8 + j));
                    ld = ~a ^ {b[15:0], b[31:16]};
                    @(posedge clk);
                    op_sel = 5'(op); src1 = a; src2 = b; imm = im; pc = p; load_data = ld;
                    @(negedge clk);
                    exp_r = model(op, a, b, im, p);
                    addr  = a + im;
                    check(tag_of(op), "result", result, exp_r);
                    // R9: write strobe only for STORE, read strobe only for LOAD
                    check("R9", "mem_we", {31'b0, mem_we}, {31'b0, op == 25});
                    check("R9", "mem_re", {31'b0, mem_re}, {31'b0, op == 24});
                    check("R9", "mem_wdata", mem_wdata, b);
                    if (op == 24 || op == 25)
                        check("R9", "mem_idx", {27'b0, mem_idx}, {27'b0, addr[6:2]});
                    // R10: write-back selection
                    check("R10", "rf_wdata", rf_wdata, (op == 24) ? ld : exp_r);
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule